// File: doc/BRIEF.md
# Cellular Automaton Pattern Generator

This block produces a stream of pseudo-random words from a one-dimensional ring of binary cells. The current word is held in a register with one bit per cell. When a step is requested, every cell takes a new value in the same clock edge. The new value comes from an 8-bit rule, indexed by the cell itself and its two adjacent cells. The ring has no ends: the highest and lowest cells count as adjacent to each other.

Software or a controlling state machine first seeds the ring. It places a word on the seed input and pulses the load strobe for one cycle. After that, each pulse of the step strobe advances the ring by one generation. Between steps the pattern holds.

The rule register starts at 30 after reset. Rule 30 gives chaotic, non-repeating behaviour. A write strobe can replace the rule at run time, and the new rule governs every generation after the write.

Top module: `ca_ring_gen`

## Requirements
- R1: While `rst` is high at a clock edge, the pattern register becomes all zero and the rule register becomes 30. Both values are visible on the cycle after the reset edge.
- R2: When `seed_load_i` is high at an edge, `pattern_o` after that edge equals the `seed_i` value sampled at that edge.
- R3: When `seed_load_i` and `step_i` are both high at one edge, the seed is loaded and is not advanced.
- R4: When neither `seed_load_i` nor `step_i` is high at an edge, `pattern_o` keeps its value.
- R5: On a step edge (step high, load low), each bit i of `pattern_o` becomes bit k of the rule register, where k = 4*cell(i+1) + 2*cell(i) + 1*cell(i-1). Bit i is cell i, and cell indices are taken modulo CELLS.
- R6: The ring wraps. Cell 0 takes cell CELLS-1 as its lower neighbour, and cell CELLS-1 takes cell 0 as its upper neighbour.
- R7: When `rule_wr_i` is high at an edge, the rule register takes `rule_i`. A step at that same edge still uses the previous rule. Steps at later edges use the new rule.
- R8: When rule bit 0 is clear, as it is for rule 30, stepping an all-zero pattern leaves the pattern all zero.
- R9: After reset, with no rule write, steps follow rule 30 (binary 00011110). From a single-bit seed this gives next = upper XOR (self OR lower).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| seed_i | input | CELLS | Word to load into the ring |
| seed_load_i | input | 1 | One-cycle strobe that loads `seed_i` |
| step_i | input | 1 | One-cycle request to advance one generation |
| rule_i | input | 8 | New update rule |
| rule_wr_i | input | 1 | One-cycle strobe that writes `rule_i` into the rule register |
| pattern_o | output | CELLS | Current ring state, registered |

## Verification
The checker watches several properties on every cycle:
- the value after reset;
- that a load captures the seed, including when a step arrives at the same edge;
- that the pattern holds when idle;
- that a rule write lands in the rule register;
- that an all-zero ring under a rule with bit 0 clear stays at zero;
- the next-value lookup at the two wrap cells.

The bench scenarios cover what needs history or a reference. They compare whole generations against an independent model from single-bit seeds at both ends of the ring and from a dense seed. They also check that a rule written in the same cycle as a step only takes effect on the following step, and that a second reset restores rule 30.

// File: rtl/ca_pkg.sv
package ca_pkg;
  localparam int RULE_W = 8;
  localparam int NBR_W  = 3;
  typedef logic [RULE_W-1:0] rule_t;
  localparam rule_t RULE_DEFAULT = 8'd30;
endpackage

// File: rtl/ca_rule_reg.sv
module ca_rule_reg
  import ca_pkg::*;
#(
  parameter rule_t RESET_RULE = RULE_DEFAULT
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  wr_i,
  input  rule_t rule_i,
  output rule_t rule_o
);
  rule_t rule_q;

  always_ff @(posedge clk) begin
    if (rst)       rule_q <= RESET_RULE;
    else if (wr_i) rule_q <= rule_i;
  end

  assign rule_o = rule_q;
endmodule

// File: rtl/ca_cell_next.sv
module ca_cell_next
  import ca_pkg::*;
(
  input  logic  upper_i,
  input  logic  self_i,
  input  logic  lower_i,
  input  rule_t rule_i,
  output logic  next_o
);
  logic [NBR_W-1:0] idx;

  always_comb begin
    idx    = {upper_i, self_i, lower_i};
    next_o = rule_i[idx];
  end
endmodule

// File: rtl/ca_next_gen.sv
module ca_next_gen
  import ca_pkg::*;
#(
  parameter int CELLS = 32
) (
  input  logic [CELLS-1:0] cur_i,
  input  rule_t            rule_i,
  output logic [CELLS-1:0] nxt_o
);
  for (genvar i = 0; i < CELLS; i++) begin : g_cell
    localparam int UP = (i + 1) % CELLS;
    localparam int DN = (i + CELLS - 1) % CELLS;

    ca_cell_next u_cell (
      .upper_i (cur_i[UP]),
      .self_i  (cur_i[i]),
      .lower_i (cur_i[DN]),
      .rule_i  (rule_i),
      .next_o  (nxt_o[i])
    );
  end
endmodule

// File: rtl/ca_ring_gen.sv
module ca_ring_gen
  import ca_pkg::*;
#(
  parameter int    CELLS      = 32,
  parameter rule_t RESET_RULE = RULE_DEFAULT
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CELLS-1:0] seed_i,
  input  logic             seed_load_i,
  input  logic             step_i,
  input  logic [7:0]       rule_i,
  input  logic             rule_wr_i,
  output logic [CELLS-1:0] pattern_o
);
  rule_t            rule_q;
  logic [CELLS-1:0] ring_q;
  logic [CELLS-1:0] ring_nxt;

  ca_rule_reg #(.RESET_RULE(RESET_RULE)) u_rule (
    .clk    (clk),
    .rst    (rst),
    .wr_i   (rule_wr_i),
    .rule_i (rule_i),
    .rule_o (rule_q)
  );

  ca_next_gen #(.CELLS(CELLS)) u_gen (
    .cur_i  (ring_q),
    .rule_i (rule_q),
    .nxt_o  (ring_nxt)
  );

  // load has priority over step
  always_ff @(posedge clk) begin
    if (rst)              ring_q <= '0;
    else if (seed_load_i) ring_q <= seed_i;
    else if (step_i)      ring_q <= ring_nxt;
  end

  assign pattern_o = ring_q;
endmodule

// File: rtl/ca_ring_gen_chk.sv
module ca_ring_gen_chk #(
  parameter int CELLS = 32
) (
  input logic             clk,
  input logic             rst,
  input logic [CELLS-1:0] seed_i,
  input logic             seed_load_i,
  input logic             step_i,
  input logic [7:0]       rule_i,
  input logic             rule_wr_i,
  input logic [CELLS-1:0] pattern_o,
  input logic [7:0]       rule_q
);
  logic [2:0] idx_low;
  logic [2:0] idx_high;
  logic       stepping;

  assign idx_low  = {pattern_o[1], pattern_o[0], pattern_o[CELLS-1]};
  assign idx_high = {pattern_o[0], pattern_o[CELLS-1], pattern_o[CELLS-2]};
  assign stepping = step_i && !seed_load_i;

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    $fell(rst) |-> (pattern_o == '0 && rule_q == 8'd30));

  // R2
  seed_capture_chk: assert property (@(posedge clk) disable iff (rst)
    seed_load_i |=> pattern_o == $past(seed_i));

  // R3
  load_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (seed_load_i && step_i) |=> pattern_o == $past(seed_i));

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!seed_load_i && !step_i) |=> $stable(pattern_o));

  // R7
  rule_write_chk: assert property (@(posedge clk) disable iff (rst)
    rule_wr_i |=> rule_q == $past(rule_i));

  // R8
  zero_fixed_chk: assert property (@(posedge clk) disable iff (rst)
    (stepping && pattern_o == '0 && !rule_q[0]) |=> pattern_o == '0);

  // R6
  wrap_low_chk: assert property (@(posedge clk) disable iff (rst)
    stepping |=> pattern_o[0] == $past(rule_q[idx_low]));

  // R6
  wrap_high_chk: assert property (@(posedge clk) disable iff (rst)
    stepping |=> pattern_o[CELLS-1] == $past(rule_q[idx_high]));
endmodule

bind ca_ring_gen ca_ring_gen_chk #(.CELLS(CELLS)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .seed_i      (seed_i),
  .seed_load_i (seed_load_i),
  .step_i      (step_i),
  .rule_i      (rule_i),
  .rule_wr_i   (rule_wr_i),
  .pattern_o   (pattern_o),
  .rule_q      (rule_q)
);

// File: tb/ca_ring_gen_tb.sv
module ca_ring_gen_tb;
  localparam int N = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] seed_i = '0;
  logic         seed_load_i = 1'b0;
  logic         step_i = 1'b0;
  logic [7:0]   rule_i = '0;
  logic         rule_wr_i = 1'b0;
  logic [N-1:0] pattern_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [N-1:0] exp_q[$];
  string        tag_q[$];
  logic [N-1:0] model = '0;
  logic [7:0]   mrule = 8'd30;

  always #4 clk = ~clk;

  ca_ring_gen #(.CELLS(N)) u_dut (
    .clk(clk), .rst(rst), .seed_i(seed_i), .seed_load_i(seed_load_i),
    .step_i(step_i), .rule_i(rule_i), .rule_wr_i(rule_wr_i),
    .pattern_o(pattern_o)
  );

  function automatic logic [N-1:0] gen(logic [N-1:0] s, logic [7:0] r);
    logic [N-1:0] o;
    for (int i = 0; i < N; i++) begin
      logic [2:0] k;
      k = {s[(i + 1) % N], s[i], s[(i + N - 1) % N]};
      o[i] = r[k];
    end
    return o;
  endfunction

  task automatic op(input bit rs, input bit ld, input logic [N-1:0] sd,
                    input bit st, input bit wr, input logic [7:0] rl,
                    input string tag);
    @(negedge clk);
    rst = rs; seed_load_i = ld; seed_i = sd; step_i = st;
    rule_wr_i = wr; rule_i = rl;
    if (rs) begin
      model = '0; mrule = 8'd30;
    end else begin
      if (ld)      model = sd;
      else if (st) model = gen(model, mrule);
      if (wr) mrule = rl;
    end
    exp_q.push_back(model);
    tag_q.push_back(tag);
  endtask

  task automatic idle(input string tag);
    op(1'b0, 1'b0, '0, 1'b0, 1'b0, 8'd0, tag);
  endtask

  task automatic step(input string tag);
    op(1'b0, 1'b0, '0, 1'b1, 1'b0, 8'd0, tag);
  endtask

  task automatic load(input logic [N-1:0] sd, input string tag);
    op(1'b0, 1'b1, sd, 1'b0, 1'b0, 8'd0, tag);
  endtask

  // monitor: compares one item per cycle, just after the edge it refers to
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        logic [N-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (pattern_o !== e) begin
          errors++;
          $display("FAIL %s: pattern actual=%h expected=%h", t, pattern_o, e);
        end
      end
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R1: reset clears the ring
    op(1'b1, 1'b0, '0, 1'b0, 1'b0, 8'd0, "R1 reset");
    op(1'b1, 1'b1, 32'hFFFF_FFFF, 1'b1, 1'b0, 8'd0, "R1 reset beats load");
    idle("R1 after reset");
    // R8: zero ring is a fixed point of rule 30
    for (int i = 0; i < 3; i++) step("R8 zero fixed point");
    // R9 / R5: single-bit seed at cell 0, wrap exercised (R6)
    load(32'h0000_0001, "R2 load bit0");
    for (int i = 0; i < 8; i++) step("R9 rule30 from bit0 (R6 wrap)");
    load(32'h8000_0000, "R2 load bit31");
    for (int i = 0; i < 5; i++) step("R6 wrap from bit31");
    // R4: hold
    for (int i = 0; i < 3; i++) idle("R4 hold");
    // R3: load and step together
    op(1'b0, 1'b1, 32'h1234_5678, 1'b1, 1'b0, 8'd0, "R3 load beats step");
    idle("R3 no advance");
    load(32'hA5C3_1E77, "R2 dense seed");
    for (int i = 0; i < 5; i++) step("R5 dense seed generations");
    // R7: rule write with a step in the same cycle uses the old rule
    op(1'b0, 1'b0, '0, 1'b1, 1'b1, 8'd90, "R7 same-cycle step uses old rule");
    for (int i = 0; i < 3; i++) step("R7 rule 90 applies");
    op(1'b0, 1'b0, '0, 1'b0, 1'b1, 8'd110, "R7 write while idle");
    load(32'h0001_0000, "R2 reseed");
    for (int i = 0; i < 4; i++) step("R5 rule 110");
    // R1: second reset restores rule 30
    op(1'b1, 1'b0, '0, 1'b0, 1'b0, 8'd0, "R1 second reset");
    load(32'h0000_0100, "R2 load after reset");
    for (int i = 0; i < 4; i++) step("R1 rule back to 30");
    idle("R4 final hold");
    idle("R4 final hold");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule